// File: doc/BRIEF.md
# Flash Write-Protection Guard

This block keeps the write-protection state of a serial flash array and answers protection questions about it. It holds a three-bit protection size code and a lock bit. The size code is decoded into a protected range of 64 KB blocks. That range grows in powers of two from one end of the array, and a parameter picks which end. A command decoder upstream passes in single-cycle strobes for the commands it has fully received. This block tracks whether the most recent command armed a status write. It then accepts or refuses each status write, using the write-protect pin level and the lock bit.

The query side is purely combinational. An address presented on `qry_addr_i` is judged against the current range in the same cycle. A separate flag reports whether a whole-array erase may proceed. The block also assembles the status byte that the serial front end shifts out. Busy, write-enable and sequential-programming flags come in from elsewhere and are simply placed at their bit positions. All pins are plain control and status signals. No stream or handshake exists at the edge of this block.

Top module: `flash_wp_guard`

## Requirements
- R1: While reset is held and after it is released, the size code reads 3'b111 and the lock bit reads 0. Every queried address is then protected and whole-array erase is refused.
- R2: The status byte on `status_o` has the following layout. Bit 0 is `busy_i`, bit 1 is `wel_i`, bits 4:2 are the size code, bit 5 is always 0, bit 6 is `seq_i` and bit 7 is the lock bit.
- R3: The size code decodes to a number of protected blocks. Code 0 protects no block. Codes 1, 2, 3, 4 and 5 protect 1, 2, 4, 8 and 16 blocks. Codes 6 and 7 protect all 32 blocks.
- R4: With `TOP_ANCHOR=1`, the protected blocks are the highest-numbered ones, so the range always ends at address 1FFFFFh. With `TOP_ANCHOR=0`, they are the lowest-numbered ones, so the range always starts at 000000h.
- R5: `addr_prot_o` depends only on address bits 20:16 (the block number) and the current size code. It follows a change of `qry_addr_i` in the same cycle, with no clock edge in between.
- R6: A status write (`wsr_stb_i`) is considered only when the previous command strobe was `ewsr_stb_i` or `wren_stb_i`. An intervening `other_stb_i` discards the arming. Every status write strobe consumes the arming, whether the write is accepted or not.
- R7: An armed status write is refused when `wp_pin_i` is 0 and the lock bit is 1. A refused write leaves the size code and the lock bit unchanged and produces no `wel_clr_o` pulse.
- R8: An armed status write with `wp_pin_i` at 0 and the lock bit at 0 loads the size code from value bits 4:2 and the lock bit from value bit 7. The lock bit can therefore be set while the pin is low, but never cleared.
- R9: An armed status write with `wp_pin_i` at 1 loads value bits 4:2 and bit 7 whatever the lock bit is. This includes clearing the lock bit.
- R10: An accepted status write raises `wel_clr_o` for exactly one cycle. The pulse appears in the cycle after the strobe, together with the new register values.
- R11: `chip_erase_ok_o` is 1 exactly when the size code is 0.
- R12: Value bits 6, 5, 1 and 0 of `wr_val_i` never change any state or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the power-up protection state |
| ewsr_stb_i | input | 1 | Enable-status-write command received (arms) |
| wren_stb_i | input | 1 | Write-enable command received (also arms) |
| wsr_stb_i | input | 1 | Status-write command with its value byte received |
| other_stb_i | input | 1 | Any other command received (disarms) |
| wr_val_i | input | 8 | Value byte of the status write |
| wp_pin_i | input | 1 | Write-protect pin level, 0 enables the lock |
| busy_i | input | 1 | Internal operation in progress, placed in status bit 0 |
| wel_i | input | 1 | Write-enable latch, placed in status bit 1 |
| seq_i | input | 1 | Sequential programming mode, placed in status bit 6 |
| qry_addr_i | input | 21 | Byte address being checked |
| status_o | output | 8 | Assembled status byte |
| bp_o | output | 3 | Current protection size code |
| lock_o | output | 1 | Current lock bit |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |
| addr_prot_o | output | 1 | Queried address lies in the protected range |
| chip_erase_ok_o | output | 1 | Whole-array erase allowed |

## Verification
The bench goes after arming that survives an intervening unrelated command. A design with that fault would accept a status write the protocol forbids, so the size code would change when it should stay. It also targets the lock bit under a low pin. A faulty design would either clear the lock or accept a write while locked, and would show up as a lock or size-code change together with a spurious `wel_clr_o` pulse. Block-boundary queries are run on both a top-anchored and a bottom-anchored instance. An off-by-one in the span, or a swapped anchor, would flag the block just outside the range, or miss the one just inside. Codes 6 and 7 are checked for whole-array coverage. The ignored value bits are randomized on every write to catch decoding from the wrong positions.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  // status byte bit positions (other blocks decode these)
  localparam int unsigned SR_BUSY  = 0;
  localparam int unsigned SR_WEL   = 1;
  localparam int unsigned SR_BP_LO = 2;
  localparam int unsigned SR_BP_HI = 4;
  localparam int unsigned SR_RSVD  = 5;
  localparam int unsigned SR_SEQ   = 6;
  localparam int unsigned SR_LOCK  = 7;

  localparam int unsigned BP_W = SR_BP_HI - SR_BP_LO + 1;

  // power-up value of the size code: everything protected
  localparam logic [BP_W-1:0] BP_RESET = '1;

  // Number of protected blocks for a size code, given log2 of the block count.
  function automatic int unsigned span_of(input logic [BP_W-1:0] code,
                                          input int unsigned blk_w);
    int unsigned c;
    c = int'(code);
    if (c == 0) return 0;
    if (c - 1 >= blk_w) return 1 << blk_w;
    return 1 << (c - 1);
  endfunction

endpackage

// File: rtl/flash_wp_arm.sv
module flash_wp_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_stb_i,
  input  logic wsr_stb_i,
  input  logic other_stb_i,
  output logic armed_o
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         armed_q <= 1'b0;
    else if (wsr_stb_i || other_stb_i)  armed_q <= 1'b0;
    else if (arm_stb_i)                 armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  // R6
  other_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    other_stb_i |=> !armed_o);

  // R6
  wsr_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wsr_stb_i |=> !armed_o);

endmodule

// File: rtl/flash_wp_sreg.sv
module flash_wp_sreg
  import flash_wp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wsr_stb_i,
  input  logic            armed_i,
  input  logic            wp_pin_i,
  input  logic [7:0]      wr_val_i,
  output logic [BP_W-1:0] bp_o,
  output logic            lock_o,
  output logic            wel_clr_o
);

  logic [BP_W-1:0] bp_q;
  logic            lock_q;
  logic            clr_q;
  logic            accept;
  logic            unused_val_bits;

  assign unused_val_bits = ^{wr_val_i[SR_SEQ], wr_val_i[SR_RSVD],
                             wr_val_i[SR_WEL], wr_val_i[SR_BUSY]};

  // lock only bites when the pin is low
  assign accept = wsr_stb_i && armed_i && (wp_pin_i || !lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= BP_RESET;
      lock_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= accept;
      if (accept) begin
        bp_q   <= wr_val_i[SR_BP_HI:SR_BP_LO];
        lock_q <= wr_val_i[SR_LOCK];
      end
    end
  end

  assign bp_o      = bp_q;
  assign lock_o    = lock_q;
  assign wel_clr_o = clr_q;

  // R7
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_pin_i && lock_o) |=> ($stable(bp_o) && lock_o && !wel_clr_o));

  // R8
  lock_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_pin_i && lock_o) |=> lock_o);

  // R10
  clr_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |-> $past(wsr_stb_i && armed_i));

  // R6
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wsr_stb_i && armed_i) |=> ($stable(bp_o) && $stable(lock_o) && !wel_clr_o));

endmodule

// File: rtl/flash_wp_map.sv
module flash_wp_map
  import flash_wp_pkg::*;
#(
  parameter int unsigned BLK_W      = 5,
  parameter bit          TOP_ANCHOR = 1'b1
) (
  input  logic [BP_W-1:0]  bp_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             prot_o
);

  localparam logic [BLK_W:0] NBLK = (BLK_W+1)'(1 << BLK_W);

  logic [BLK_W:0] span;
  logic [BLK_W:0] blk_x;

  assign span  = (BLK_W+1)'(span_of(bp_i, BLK_W));
  assign blk_x = {1'b0, blk_i};

  generate
    if (TOP_ANCHOR) begin : g_top
      assign prot_o = (span != '0) && (blk_x >= (NBLK - span));
    end else begin : g_bot
      assign prot_o = (blk_x < span);
    end
  endgenerate

endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned BLK_LSB    = 16,
  parameter bit          TOP_ANCHOR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ewsr_stb_i,
  input  logic              wren_stb_i,
  input  logic              wsr_stb_i,
  input  logic              other_stb_i,
  input  logic [7:0]        wr_val_i,
  input  logic              wp_pin_i,
  input  logic              busy_i,
  input  logic              wel_i,
  input  logic              seq_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic [7:0]        status_o,
  output logic [2:0]        bp_o,
  output logic              lock_o,
  output logic              wel_clr_o,
  output logic              addr_prot_o,
  output logic              chip_erase_ok_o
);

  localparam int unsigned BLK_W = ADDR_W - BLK_LSB;

  logic             armed;
  logic [BP_W-1:0]  bp;
  logic             lock;
  logic [BLK_W-1:0] qry_blk;
  logic [BLK_LSB-1:0] unused_offset;

  assign qry_blk       = qry_addr_i[ADDR_W-1:BLK_LSB];
  assign unused_offset = qry_addr_i[BLK_LSB-1:0];

  flash_wp_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_stb_i  (ewsr_stb_i | wren_stb_i),
    .wsr_stb_i  (wsr_stb_i),
    .other_stb_i(other_stb_i),
    .armed_o    (armed)
  );

  flash_wp_sreg u_sreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wsr_stb_i(wsr_stb_i),
    .armed_i  (armed),
    .wp_pin_i (wp_pin_i),
    .wr_val_i (wr_val_i),
    .bp_o     (bp),
    .lock_o   (lock),
    .wel_clr_o(wel_clr_o)
  );

  flash_wp_map #(
    .BLK_W     (BLK_W),
    .TOP_ANCHOR(TOP_ANCHOR)
  ) u_map (
    .bp_i  (bp),
    .blk_i (qry_blk),
    .prot_o(addr_prot_o)
  );

  always_comb begin
    status_o                   = '0;
    status_o[SR_BUSY]          = busy_i;
    status_o[SR_WEL]           = wel_i;
    status_o[SR_BP_HI:SR_BP_LO] = bp;
    status_o[SR_SEQ]           = seq_i;
    status_o[SR_LOCK]          = lock;
  end

  assign bp_o            = bp;
  assign lock_o          = lock;
  assign chip_erase_ok_o = (bp == '0);

  // R3
  none_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_o == 3'd0) |-> !addr_prot_o);

  // R3
  all_when_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bp_o) > int'(BLK_W)) |-> addr_prot_o);

  // R11
  erase_vs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_ok_o |-> !addr_prot_o);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[SR_RSVD] == 1'b0);

  generate
    if (TOP_ANCHOR) begin : g_top_chk
      // R4
      top_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bp_o != 3'd0) && (&qry_addr_i[ADDR_W-1:BLK_LSB])) |-> addr_prot_o);
    end else begin : g_bot_chk
      // R4
      bot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bp_o != 3'd0) && (qry_addr_i[ADDR_W-1:BLK_LSB] == '0)) |-> addr_prot_o);
    end
  endgenerate

endmodule

// File: tb/flash_wp_guard_bench.sv
module flash_wp_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ewsr = 0, wren = 0, wsr = 0, other = 0;
  logic [7:0]  val = 8'h00;
  logic        wp = 1'b1, busy = 0, wel = 0, seq = 0;
  logic [20:0] addr = '0;

  logic [7:0] st_t, st_b;
  logic [2:0] bp_t, bp_b;
  logic       lk_t, lk_b, clr_t, clr_b, pr_t, pr_b, ce_t, ce_b;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [2:0] m_bp = 3'b111;
  logic       m_lock = 0, m_armed = 0, m_clr = 0;

  always #5 clk = ~clk;

  flash_wp_guard #(.TOP_ANCHOR(1'b1)) u_flash_wp_guard (
    .clk(clk), .rst_n(rst_n), .ewsr_stb_i(ewsr), .wren_stb_i(wren),
    .wsr_stb_i(wsr), .other_stb_i(other), .wr_val_i(val), .wp_pin_i(wp),
    .busy_i(busy), .wel_i(wel), .seq_i(seq), .qry_addr_i(addr),
    .status_o(st_t), .bp_o(bp_t), .lock_o(lk_t), .wel_clr_o(clr_t),
    .addr_prot_o(pr_t), .chip_erase_ok_o(ce_t));

  flash_wp_guard #(.TOP_ANCHOR(1'b0)) u_flash_wp_guard_bot (
    .clk(clk), .rst_n(rst_n), .ewsr_stb_i(ewsr), .wren_stb_i(wren),
    .wsr_stb_i(wsr), .other_stb_i(other), .wr_val_i(val), .wp_pin_i(wp),
    .busy_i(busy), .wel_i(wel), .seq_i(seq), .qry_addr_i(addr),
    .status_o(st_b), .bp_o(bp_b), .lock_o(lk_b), .wel_clr_o(clr_b),
    .addr_prot_o(pr_b), .chip_erase_ok_o(ce_b));

  function automatic int span_f(input logic [2:0] c);
    if (c == 0) return 0;
    if (c >= 6) return 32;
    return 1 << (c - 1);
  endfunction

  function automatic logic prot_f(input logic [2:0] c, input logic [20:0] a,
                                  input bit top);
    int b;
    b = int'(a[20:16]);
    if (top) return (span_f(c) != 0) && (b >= 32 - span_f(c));
    return b < span_f(c);
  endfunction

  function automatic logic [7:0] stat_f();
    return {m_lock, seq, 1'b0, m_bp, wel, busy};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(bp_t == m_bp && bp_b == m_bp, req, "size code", int'(bp_t), int'(m_bp));
    chk(lk_t == m_lock && lk_b == m_lock, req, "lock", int'(lk_t), int'(m_lock));
    chk(clr_t == m_clr && clr_b == m_clr, "R10", "wel_clr", int'(clr_t), int'(m_clr));
    chk(st_t == stat_f() && st_b == stat_f(), "R2", "status", int'(st_t), int'(stat_f()));
  endtask

  task automatic query(input logic [20:0] a, input string req);
    addr = a;
    #1;
    chk(pr_t == prot_f(m_bp, a, 1), req, "top prot", int'(pr_t), int'(prot_f(m_bp, a, 1)));
    chk(pr_b == prot_f(m_bp, a, 0), req, "bottom prot", int'(pr_b), int'(prot_f(m_bp, a, 0)));
    chk(ce_t == (m_bp == 0) && ce_b == (m_bp == 0), "R11", "erase ok",
        int'(ce_t), int'(m_bp == 0));
  endtask

  // kind: 0 idle, 1 ewsr, 2 wren, 3 status write, 4 other
  task automatic op(input int kind, input logic [7:0] v, input logic pin,
                    input string req);
    @(negedge clk);
    ewsr = (kind == 1); wren = (kind == 2); wsr = (kind == 3); other = (kind == 4);
    val = v; wp = pin;
    m_clr = 0;
    if (kind == 3) begin
      if (m_armed && (pin || !m_lock)) begin
        m_bp = v[4:2]; m_lock = v[7]; m_clr = 1;
      end
      m_armed = 0;
    end else if (kind == 4) m_armed = 0;
    else if (kind == 1 || kind == 2) m_armed = 1;
    @(negedge clk);
    ewsr = 0; wren = 0; wsr = 0; other = 0;
    #1;
    chk_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state, whole array protected
    chk_state("R1");
    query(21'h000000, "R1");
    query(21'h1FFFFF, "R1");
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_state("R1");
    query(21'h0ABCDE, "R1");

    // R6 unarmed write ignored
    op(3, 8'h00, 1, "R6");
    // R6 arming discarded by an intervening command
    op(2, 8'h00, 1, "R6");
    op(4, 8'h00, 1, "R6");
    op(3, 8'h00, 1, "R6");
    // R9 armed write with pin high clears protection, R10 pulse, R11
    op(1, 8'h00, 1, "R9");
    op(3, 8'h63, 1, "R9");   // R12: bits 6,5,1,0 set but ignored
    query(21'h1F0000, "R11");
    op(0, 8'h00, 1, "R10");  // pulse lasts one cycle

    // R3 R4 R5 sweep every code across block boundaries
    for (int c = 1; c < 8; c++) begin
      op(2, 8'h00, 1, "R6");
      op(3, 8'(c << 2), 1, "R3");
      for (int b = 0; b < 32; b++) begin
        query({5'(b), 16'h0000}, "R4");
        query({5'(b), 16'hFFFF}, "R5");
      end
    end

    // R8 pin low, lock clear: lock can be set
    op(1, 8'h00, 0, "R8");
    op(3, 8'h8C, 0, "R8");
    // R7 pin low, locked: refused, no pulse
    op(1, 8'h00, 0, "R7");
    op(3, 8'h00, 0, "R7");
    query(21'h1F8000, "R7");
    // R9 pin high: lock cleared
    op(2, 8'h00, 1, "R9");
    op(3, 8'h04, 1, "R9");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      busy = 1'($urandom); wel = 1'($urandom); seq = 1'($urandom);
      op(int'($urandom % 5), 8'($urandom), 1'($urandom % 3 != 0), "R12");
      query(21'($urandom), "R5");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule